// File: doc/BRIEF.md
# Serial Transmit DMA Engine

This block drains a region of system memory into a serial transmit byte stream without processor involvement. Software first loads a source pointer through a small register port. It then writes a byte count, and that write alone starts the transfer. The engine fetches one byte at a time over a request/response memory read port and presents each byte on a valid/ready transmit stream. The pointer advances by one after every byte the stream accepts.

When the `sink_present` input is low, no transmit consumer is attached. A nonzero count write then moves no data; it only advances the pointer by the full count in one step. The count register has no stored value and always reads back as zero. Only one byte is ever in flight: the engine issues the next memory read only after the previous byte has left on the transmit stream.

The controller is a four-state machine:
- `ST_IDLE`: waiting for a count write.
- `ST_FETCH`: the memory read request is held until it is accepted.
- `ST_WAIT`: waiting for the read response.
- `ST_SEND`: the byte is offered on the stream.

Transitions:
- `ST_IDLE`→`ST_FETCH` on a nonzero count write with a sink present.
- `ST_FETCH`→`ST_WAIT` when the request is accepted.
- `ST_WAIT`→`ST_SEND` when the response arrives.
- `ST_SEND`→`ST_FETCH` when a byte is accepted and more remain.
- `ST_SEND`→`ST_IDLE` when the final byte is accepted.

Top module: `txdma_top`

## Requirements
- R1: After reset `busy`, `mem_req_valid` and `tx_valid` are low and the pointer (register index 4) reads 0.
- R2: A write to register index 4 while idle loads the pointer, and a read of index 4 returns the current pointer.
- R3: A write of a nonzero count N to register index 5 while idle, with `sink_present` high, fetches N bytes from consecutive addresses starting at the pointer and delivers them on `tx_data` in address order.
- R4: A count write of zero starts nothing: `busy` stays low, no memory request is issued and the pointer is unchanged.
- R5: The pointer increases by exactly one on each transmit handshake and equals start + N when a transfer completes.
- R6: With `sink_present` low, a nonzero count write leaves `busy` low, issues no memory request, and makes the pointer read start + N from the next cycle.
- R7: A read of register index 5 returns zero, as does a read of any index other than 4.
- R8: `busy` rises in the cycle after the starting count write and falls in the cycle after the final transmit handshake; while `busy` is low, neither `mem_req_valid` nor `tx_valid` is asserted.
- R9: Writes to index 4 or index 5 while `busy` is high are ignored: the transfer length and the pointer sequence are unchanged.
- R10: At most one byte is in flight, so `mem_req_valid` is never high together with `tx_valid`. A pending request holds its address, and a pending byte holds its value until accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | IDX_W | Register index (4 pointer, 5 count) |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for `reg_idx` (combinational) |
| sink_present | input | 1 | High when a transmit consumer is attached |
| busy | output | 1 | Transfer in progress |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory read request accepted |
| mem_req_addr | output | ADDR_W | Byte address of the read (current pointer) |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | 8 | Read response byte |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 1 | Transmit stream ready |
| tx_data | output | 8 | Transmit byte |

## Verification
Register effects land one edge after the write: the pointer reload, the skip-ahead when no sink is attached, and `busy` rising. The bench therefore drives writes at a falling edge and reads back at the following falling edge. The memory responder answers exactly one edge after it accepts a request. A byte is scored at the falling edge before the rising edge on which `tx_valid` and `tx_ready` meet. Because `busy` drops one edge after the final handshake, the bench waits an extra falling edge after the last byte before checking `busy` and the final pointer.

// File: rtl/txdma_pkg.sv
package txdma_pkg;
    localparam int unsigned IDX_PTR = 4;
    localparam int unsigned IDX_CNT = 5;
    localparam int unsigned BYTE_W  = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_WAIT  = 2'd2,
        ST_SEND  = 2'd3
    } txdma_state_e;
endpackage

// File: rtl/txdma_regs.sv
module txdma_regs
    import txdma_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              busy,
    input  logic              sink_present,
    input  logic              step,
    output logic              start,
    output logic [DATA_W-1:0] start_count,
    output logic [ADDR_W-1:0] ptr,
    output logic [DATA_W-1:0] reg_rdata
);
    localparam logic [IDX_W-1:0] PTR_SEL = IDX_W'(IDX_PTR);
    localparam logic [IDX_W-1:0] CNT_SEL = IDX_W'(IDX_CNT);

    logic ptr_load;
    logic cnt_write;
    logic cnt_nonzero;
    logic skip;
    logic [ADDR_W-1:0] ptr_q;

    // Writes are only honoured while the engine is idle.
    assign ptr_load    = reg_wr && (reg_idx == PTR_SEL) && !busy;
    assign cnt_write   = reg_wr && (reg_idx == CNT_SEL) && !busy;
    assign cnt_nonzero = |reg_wdata;
    assign start       = cnt_write && cnt_nonzero && sink_present;
    assign skip        = cnt_write && cnt_nonzero && !sink_present;
    assign start_count = reg_wdata;
    assign ptr         = ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (ptr_load) begin
            ptr_q <= ADDR_W'(reg_wdata);
        end else if (skip) begin
            ptr_q <= ptr_q + ADDR_W'(reg_wdata);
        end else if (step) begin
            ptr_q <= ptr_q + ADDR_W'(1);
        end
    end

    // Count index has no storage and reads as zero.
    always_comb begin
        reg_rdata = '0;
        if (reg_idx == PTR_SEL) begin
            reg_rdata = DATA_W'(ptr_q);
        end
    end
endmodule

// File: rtl/txdma_fsm.sv
module txdma_fsm
    import txdma_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] start_count,
    input  logic [ADDR_W-1:0] ptr,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    input  logic [BYTE_W-1:0] mem_rsp_data,
    input  logic              tx_ready,
    output logic              busy,
    output logic              step,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data
);
    txdma_state_e state_q, state_d;
    logic [DATA_W-1:0] remain_q;
    logic [BYTE_W-1:0] byte_q;
    logic              last_byte;

    assign last_byte = (remain_q == DATA_W'(1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start)          state_d = ST_FETCH;
            ST_FETCH: if (mem_req_ready)  state_d = ST_WAIT;
            ST_WAIT:  if (mem_rsp_valid)  state_d = ST_SEND;
            ST_SEND:  if (tx_ready)       state_d = last_byte ? ST_IDLE : ST_FETCH;
            default:                      state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= '0;
            byte_q   <= '0;
        end else begin
            if (state_q == ST_IDLE && start) begin
                remain_q <= start_count;
            end else if (state_q == ST_SEND && tx_ready) begin
                remain_q <= remain_q - DATA_W'(1);
            end
            if (state_q == ST_WAIT && mem_rsp_valid) begin
                byte_q <= mem_rsp_data;
            end
        end
    end

    always_comb begin
        busy          = 1'b1;
        step          = 1'b0;
        mem_req_valid = 1'b0;
        tx_valid      = 1'b0;
        unique case (state_q)
            ST_IDLE:  busy          = 1'b0;
            ST_FETCH: mem_req_valid = 1'b1;
            ST_WAIT:  ;
            ST_SEND: begin
                tx_valid = 1'b1;
                step     = tx_ready;
            end
            default:  busy          = 1'b0;
        endcase
    end

    assign mem_req_addr = ptr;
    assign tx_data      = byte_q;
endmodule

// File: rtl/txdma_top.sv
module txdma_top
    import txdma_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              sink_present,
    output logic              busy,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [7:0]        mem_rsp_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_data
);
    logic              start;
    logic              step;
    logic [DATA_W-1:0] start_count;
    logic [ADDR_W-1:0] ptr;

    txdma_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr       (reg_wr),
        .reg_idx      (reg_idx),
        .reg_wdata    (reg_wdata),
        .busy         (busy),
        .sink_present (sink_present),
        .step         (step),
        .start        (start),
        .start_count  (start_count),
        .ptr          (ptr),
        .reg_rdata    (reg_rdata)
    );

    txdma_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .start_count   (start_count),
        .ptr           (ptr),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .tx_ready      (tx_ready),
        .busy          (busy),
        .step          (step),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr),
        .tx_valid      (tx_valid),
        .tx_data       (tx_data)
    );
endmodule

// File: rtl/txdma_chk.sv
module txdma_chk #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IDX_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [IDX_W-1:0]  reg_idx,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              busy,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [7:0]        tx_data
);
    // R10
    one_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !mem_req_valid);

    // R10
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req_valid && !tx_valid));

    // R7
    cnt_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_idx == IDX_W'(5)) |-> (reg_rdata == '0));

    // R5
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> (mem_req_addr == $past(mem_req_addr) + ADDR_W'(1)));
endmodule

bind txdma_top txdma_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_idx       (reg_idx),
    .reg_rdata     (reg_rdata),
    .busy          (busy),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .tx_valid      (tx_valid),
    .tx_ready      (tx_ready),
    .tx_data       (tx_data)
);

// File: tb/tb_txdma_top.sv
module tb_txdma_top;
    localparam int unsigned ADDR_W = 32;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned IDX_W  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr = 1'b0;
    logic [IDX_W-1:0]  reg_idx = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic              sink_present = 1'b1;
    logic              busy;
    logic              mem_req_valid;
    logic              mem_req_ready = 1'b0;
    logic [ADDR_W-1:0] mem_req_addr;
    logic              mem_rsp_valid = 1'b0;
    logic [7:0]        mem_rsp_data = '0;
    logic              tx_valid;
    logic              tx_ready = 1'b0;
    logic [7:0]        tx_data;

    int checks = 0;
    int fails = 0;
    int bytes_seen = 0;
    int reqs_seen = 0;
    logic [ADDR_W-1:0] exp_tx_addr = '0;
    logic [ADDR_W-1:0] exp_req_addr = '0;
    bit pend = 1'b0;
    logic [7:0] pend_data = '0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    txdma_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) dut (.*);

    function automatic logic [7:0] mem_byte(input logic [ADDR_W-1:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Memory model and transmit sink, both acting at falling edges.
    initial begin
        forever begin
            @(negedge clk);
            mem_rsp_valid = pend;
            mem_rsp_data  = pend_data;
            mem_req_ready = ($urandom_range(0, 3) != 0);
            pend = mem_req_valid && mem_req_ready;
            if (pend) begin
                pend_data = mem_byte(mem_req_addr);
                reqs_seen++;
                chk(mem_req_addr == exp_req_addr, "R3 req addr", mem_req_addr, exp_req_addr);
                exp_req_addr = exp_req_addr + 1;
            end
            tx_ready = ($urandom_range(0, 2) != 0);
            if (tx_valid && tx_ready) begin
                chk(tx_data == mem_byte(exp_tx_addr), "R3 tx byte", tx_data, mem_byte(exp_tx_addr));
                exp_tx_addr = exp_tx_addr + 1;
                bytes_seen++;
            end
        end
    end

    task automatic reg_write(input int idx, input logic [DATA_W-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_idx = IDX_W'(idx); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic reg_read(input int idx, output logic [DATA_W-1:0] d);
        reg_idx = IDX_W'(idx);
        #1;
        d = reg_rdata;
    endtask

    task automatic run_xfer(input logic [ADDR_W-1:0] a, input int n, input bit poke_busy);
        logic [DATA_W-1:0] rd;
        int base;
        reg_write(4, a);
        reg_read(4, rd);
        chk(rd == a, "R2 ptr load", rd, a);
        exp_tx_addr = a; exp_req_addr = a;
        base = bytes_seen;
        reg_write(5, DATA_W'(n));
        chk(busy == 1'b1, "R8 busy rise", busy, 1);
        if (poke_busy) begin
            reg_write(5, 32'd9);
            reg_write(4, 32'hDEAD0000);
        end
        while (bytes_seen - base < n) @(negedge clk);
        @(negedge clk);
        chk(busy == 1'b0, "R8 busy fall", busy, 0);
        reg_read(4, rd);
        chk(rd == a + ADDR_W'(n), "R5 final ptr", rd, a + ADDR_W'(n));
        reg_read(5, rd);
        chk(rd == '0, "R7 count reads zero", rd, 0);
        repeat (4) @(negedge clk);
        chk(bytes_seen - base == n, poke_busy ? "R9 length unchanged" : "R3 length", bytes_seen - base, n);
    endtask

    initial begin
        logic [DATA_W-1:0] rd;
        int r0;
        void'($urandom(32'h1234));
        repeat (3) @(negedge clk);
        // R1
        chk(busy == 1'b0 && mem_req_valid == 1'b0 && tx_valid == 1'b0, "R1 idle outputs", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        reg_read(4, rd);
        chk(rd == '0, "R1 ptr reset", rd, 0);
        reg_read(7, rd);
        chk(rd == '0, "R7 unused index", rd, 0);

        // R4 zero count
        reg_write(4, 32'h100);
        r0 = reqs_seen;
        reg_write(5, 32'd0);
        chk(busy == 1'b0, "R4 no busy", busy, 0);
        repeat (4) @(negedge clk);
        chk(reqs_seen == r0, "R4 no request", reqs_seen, r0);
        reg_read(4, rd);
        chk(rd == 32'h100, "R4 ptr kept", rd, 32'h100);

        // R6 no sink
        sink_present = 1'b0;
        reg_write(5, 32'd37);
        reg_read(4, rd);
        chk(rd == 32'h125, "R6 ptr skip", rd, 32'h125);
        chk(busy == 1'b0, "R6 no busy", busy, 0);
        repeat (4) @(negedge clk);
        chk(reqs_seen == r0, "R6 no request", reqs_seen, r0);
        sink_present = 1'b1;

        // Directed corners
        run_xfer(32'h0000_0000, 1, 1'b0);
        run_xfer(32'hFFFF_FFFE, 3, 1'b0);
        run_xfer(32'h0000_2000, 4, 1'b1);   // R9

        // Random transfers
        for (int i = 0; i < 25; i++) begin
            run_xfer(ADDR_W'($urandom()), int'($urandom_range(1, 10)), 1'b0);
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule